// File: doc/BRIEF.md
# Cascaded pacer pair

This block joins two 16-bit down-counters taken from a small bank of interval counters into a single 32-bit rate generator. The first counter in the pair divides the input tick. Its terminal pulse is the only clock enable of the second counter. The second counter's terminal pulse is the pacer strobe that times data acquisition. The period of the strobe is the tick period multiplied by the product of the two divisors.

A host side writes two pending divisors without restriction. A separate update strobe copies both pending divisors into the active pair and masks each one to 16 bits. A start command puts both chosen counters into rate mode. It loads the second counter first and the first counter one cycle later, so the first stage cannot expire before the second stage holds a valid count. A stop command returns both counters to one-shot count mode and loads nothing. While the pair runs, its two channels are marked busy, and any general-purpose request to a busy channel is refused.

Every counter that is not in the pair stays available through a general-purpose port. This port reads a count, loads a count and sets the mode. Each of these counters is clocked directly by the tick.

Top module: `pacer_pair`

## Requirements
- R1: A counter in rate mode (mode bit 1) that is loaded with N decrements on each clock enable. It drives its `ch_out` bit high for exactly one cycle every N enables and then reloads N, where N = 0 means 65536. A counter in count mode (mode bit 0) decrements with wrap-around. Its `ch_out` bit rises on the enable that takes the count from 1 to 0 and then stays high until the counter is loaded or reprogrammed.
- R2: While the pair runs, the second counter decrements only on the first counter's terminal pulse. `pacer_strobe` pulses for one cycle every d1*d2 tick cycles, where d1 and d2 are the active first and second divisors.
- R3: An accepted start loads the second counter with the active second divisor on the accepting edge. It loads the first counter with the first divisor that was active at that edge on the following edge. With `tick` held high, the first strobe appears d1*d2+1 cycles after the accepting edge.
- R4: A start puts both named counters into rate mode and raises `pacer_on`. The start is ignored if both names are the same channel, if either name is not below NCH, or if the pair is already running. A stop clears `pacer_on`, puts both counters into count mode and leaves them unloaded, so neither counter advances and no strobe follows.
- R5: Writes to the pending divisors (`nxt_sel` 0 selects the first, 1 selects the second) have no effect on the active divisors until `div_update`. The update copies the low 16 bits of each pending value, so 65536 becomes a full 65536 count. It sets `div_bad` if either pending value is 0 or 1 and clears it otherwise.
- R6: `busy` has exactly the two paired channels set while `pacer_on` is high, and is all zero otherwise.
- R7: A general-purpose request is answered one cycle later with `gp_ack`. The operations are 0 = read count into `gp_rdata`, 1 = load count, and 2 = set mode from `gp_mode`. Loading a count arms the counter and clears its output. Setting the mode disarms the counter and clears its output. Operation 3, a channel not below NCH, or a busy channel (including one being claimed by a start in the same cycle) gives `gp_err` and changes nothing.
- R8: After reset all outputs are low, no counter is armed, and the pair is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counting enable of the first stage and of free counters |
| nxt_wr | input | 1 | Write a pending divisor |
| nxt_sel | input | 1 | 0 = first divisor, 1 = second divisor |
| nxt_val | input | 17 | Pending divisor value (up to 65536) |
| div_update | input | 1 | Copy pending divisors to active |
| div_bad | output | 1 | Last update saw a divisor below 2 |
| start_req | input | 1 | Start the pair |
| start_first | input | 2 | Channel used as first stage |
| start_second | input | 2 | Channel used as second stage |
| stop_req | input | 1 | Stop the pair |
| gp_req | input | 1 | General-purpose request |
| gp_op | input | 2 | 0 read, 1 load, 2 set mode, 3 invalid |
| gp_chan | input | 2 | Target channel |
| gp_mode | input | 1 | Mode for operation 2 (1 rate, 0 count) |
| gp_wdata | input | 16 | Count for operation 1 |
| gp_ack | output | 1 | Response valid |
| gp_err | output | 1 | Request refused |
| gp_rdata | output | 16 | Count returned by the last accepted read |
| busy | output | 3 | Channels held by the pair |
| ch_out | output | 3 | Per-counter output |
| pacer_strobe | output | 1 | Pacer pulse |
| pacer_on | output | 1 | Pair running |

## Verification
The bench targets the load order first. It counts the cycles from the start to the first strobe, and this count comes out one cycle short if both counters load on the same edge or if the first counter loads first. The bench also checks the masking of 65536: a design that stores the pending value without masking, or that treats 0 as empty, never pulses the first stage or pulses it at the wrong time. Further cases are pending writes made while the pair runs, which would change the period at once if the buffering were missing, and start requests that must be ignored, which would otherwise mark channels busy. A long stretch with a random tick and random commands then compares every output against a behavioural model on every cycle.

// File: rtl/pacer_pair.sv
module pacer_pair #(
  parameter int NCH = 3,
  parameter int CW  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    nxt_wr,
  input  logic                    nxt_sel,
  input  logic [CW:0]             nxt_val,
  input  logic                    div_update,
  output logic                    div_bad,
  input  logic                    start_req,
  input  logic [$clog2(NCH)-1:0]  start_first,
  input  logic [$clog2(NCH)-1:0]  start_second,
  input  logic                    stop_req,
  input  logic                    gp_req,
  input  logic [1:0]              gp_op,
  input  logic [$clog2(NCH)-1:0]  gp_chan,
  input  logic                    gp_mode,
  input  logic [CW-1:0]           gp_wdata,
  output logic                    gp_ack,
  output logic                    gp_err,
  output logic [CW-1:0]           gp_rdata,
  output logic [NCH-1:0]          busy,
  output logic [NCH-1:0]          ch_out,
  output logic                    pacer_strobe,
  output logic                    pacer_on
);
  localparam int SW = $clog2(NCH);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW:0]   TWO = (CW+1)'(2);

  logic [NCH-1:0] mode_q, arm_q, out_q, ce, tc;
  logic [CW-1:0]  cnt_q [NCH];
  logic [CW-1:0]  rld_q [NCH];
  logic [CW:0]    pend1_q, pend2_q;
  logic [CW-1:0]  act1_q, act2_q, fdiv_q;
  logic           on_q, ldf_q;
  logic [SW-1:0]  fch_q, sch_q;
  logic           tc1, start_ok, stop_ok, gp_busy, gp_bad;

  assign tc1 = on_q && arm_q[fch_q] && tick && (cnt_q[fch_q] == ONE);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ce[i]   = (on_q && sch_q == SW'(i)) ? tc1 : tick;
    assign tc[i]   = arm_q[i] && ce[i] && (cnt_q[i] == ONE);
    assign busy[i] = on_q && (fch_q == SW'(i) || sch_q == SW'(i));
  end

  assign start_ok = start_req && !on_q && (start_first != start_second) &&
                    (int'(start_first) < NCH) && (int'(start_second) < NCH);
  assign stop_ok  = stop_req && on_q;
  assign gp_busy  = (on_q && (gp_chan == fch_q || gp_chan == sch_q)) ||
                    (start_ok && (gp_chan == start_first || gp_chan == start_second));
  assign gp_bad   = (gp_op == 2'd3) || (int'(gp_chan) >= NCH) || gp_busy;

  assign ch_out   = out_q;
  assign pacer_on = on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; arm_q <= '0; out_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        cnt_q[i] <= '0;
        rld_q[i] <= '0;
      end
      pend1_q <= '0; pend2_q <= '0;
      act1_q <= '0; act2_q <= '0; fdiv_q <= '0;
      on_q <= 1'b0; ldf_q <= 1'b0; fch_q <= '0; sch_q <= '0;
      div_bad <= 1'b0; gp_ack <= 1'b0; gp_err <= 1'b0; gp_rdata <= '0;
      pacer_strobe <= 1'b0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (arm_q[i] && ce[i])
          cnt_q[i] <= (mode_q[i] && tc[i]) ? rld_q[i] : cnt_q[i] - ONE;
        out_q[i] <= mode_q[i] ? tc[i] : (out_q[i] | tc[i]);
      end
      pacer_strobe <= on_q && tc[sch_q];

      gp_ack <= gp_req;
      gp_err <= gp_req && gp_bad;
      if (gp_req && !gp_bad) begin
        case (gp_op)
          2'd0: gp_rdata <= cnt_q[gp_chan];
          2'd1: begin
            cnt_q[gp_chan] <= gp_wdata;
            rld_q[gp_chan] <= gp_wdata;
            arm_q[gp_chan] <= 1'b1;
            out_q[gp_chan] <= 1'b0;
          end
          2'd2: begin
            mode_q[gp_chan] <= gp_mode;
            arm_q[gp_chan]  <= 1'b0;
            out_q[gp_chan]  <= 1'b0;
          end
          default: ;
        endcase
      end

      if (start_ok) begin
        on_q <= 1'b1; ldf_q <= 1'b1;
        fch_q <= start_first; sch_q <= start_second;
        fdiv_q <= act1_q;
        mode_q[start_first] <= 1'b1; mode_q[start_second] <= 1'b1;
        out_q[start_first]  <= 1'b0; out_q[start_second]  <= 1'b0;
        arm_q[start_first]  <= 1'b0; arm_q[start_second]  <= 1'b1;
        cnt_q[start_second] <= act2_q; rld_q[start_second] <= act2_q;
      end else if (ldf_q) begin
        ldf_q <= 1'b0;
        arm_q[fch_q] <= 1'b1;
        cnt_q[fch_q] <= fdiv_q; rld_q[fch_q] <= fdiv_q;
      end
      if (stop_ok) begin
        on_q <= 1'b0; ldf_q <= 1'b0;
        mode_q[fch_q] <= 1'b0; mode_q[sch_q] <= 1'b0;
        arm_q[fch_q]  <= 1'b0; arm_q[sch_q]  <= 1'b0;
        out_q[fch_q]  <= 1'b0; out_q[sch_q]  <= 1'b0;
      end

      if (div_update) begin
        act1_q  <= pend1_q[CW-1:0];
        act2_q  <= pend2_q[CW-1:0];
        div_bad <= (pend1_q < TWO) || (pend2_q < TWO);
      end
      if (nxt_wr) begin
        if (nxt_sel) pend2_q <= nxt_val;
        else         pend1_q <= nxt_val;
      end
    end
  end

  a_r2_strobe_while_on: assert property (@(posedge clk) disable iff (!rst_n)
    pacer_strobe |-> $past(on_q));
  a_r3_second_loaded_first: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (arm_q[sch_q] && !arm_q[fch_q] && ldf_q));
  a_r3_first_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (ldf_q && !stop_req) |=> arm_q[fch_q]);
  a_r4_same_channel_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !on_q && start_first == start_second) |=> !on_q);
  a_r4_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && on_q) |=> (!on_q && busy == '0));
  a_r7_busy_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (gp_req && on_q && (gp_chan == fch_q || gp_chan == sch_q)) |=> (gp_ack && gp_err));
endmodule

// File: tb/pacer_pair_tb.sv
`timescale 1ns/1ps
module pacer_pair_tb;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic nxt_wr = 1'b0, nxt_sel = 1'b0;
  logic [16:0] nxt_val = '0;
  logic div_update = 1'b0;
  logic start_req = 1'b0, stop_req = 1'b0;
  logic [1:0] start_first = '0, start_second = '0;
  logic gp_req = 1'b0, gp_mode = 1'b0;
  logic [1:0] gp_op = '0, gp_chan = '0;
  logic [15:0] gp_wdata = '0;
  logic div_bad, gp_ack, gp_err, pacer_strobe, pacer_on;
  logic [15:0] gp_rdata;
  logic [NCH-1:0] busy, ch_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pacer_pair #(.NCH(NCH), .CW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .nxt_wr(nxt_wr), .nxt_sel(nxt_sel), .nxt_val(nxt_val), .div_update(div_update),
    .div_bad(div_bad), .start_req(start_req), .start_first(start_first),
    .start_second(start_second), .stop_req(stop_req), .gp_req(gp_req), .gp_op(gp_op),
    .gp_chan(gp_chan), .gp_mode(gp_mode), .gp_wdata(gp_wdata), .gp_ack(gp_ack),
    .gp_err(gp_err), .gp_rdata(gp_rdata), .busy(busy), .ch_out(ch_out),
    .pacer_strobe(pacer_strobe), .pacer_on(pacer_on));

  task automatic chk(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_mode[NCH], m_arm[NCH], m_out[NCH], m_cnt[NCH], m_rld[NCH];
  int m_p1, m_p2, m_a1, m_a2, m_fd, m_on, m_ldf, m_f, m_s;
  int m_bad, m_ack, m_err, m_rd, m_stb;

  task automatic m_reset();
    for (int i = 0; i < NCH; i++) begin
      m_mode[i] = 0; m_arm[i] = 0; m_out[i] = 0; m_cnt[i] = 0; m_rld[i] = 0;
    end
    m_p1 = 0; m_p2 = 0; m_a1 = 0; m_a2 = 0; m_fd = 0; m_on = 0; m_ldf = 0;
    m_f = 0; m_s = 0; m_bad = 0; m_ack = 0; m_err = 0; m_rd = 0; m_stb = 0;
  endtask

  task automatic m_step();
    int tcv[NCH];
    int t1, ce, sok, pok, gbad, c, rd_old, a, b;
    a = int'(start_first); b = int'(start_second); c = int'(gp_chan);
    t1 = (m_on && m_arm[m_f] && tick && m_cnt[m_f] == 1) ? 1 : 0;
    for (int i = 0; i < NCH; i++) begin
      ce = (m_on && i == m_s) ? t1 : int'(tick);
      tcv[i] = (m_arm[i] && ce && m_cnt[i] == 1) ? 1 : 0;
    end
    sok = (start_req && !m_on && a != b && a < NCH && b < NCH) ? 1 : 0;
    pok = (stop_req && m_on) ? 1 : 0;
    gbad = (gp_op == 2'd3 || c >= NCH || (m_on && (c == m_f || c == m_s)) ||
            (sok && (c == a || c == b))) ? 1 : 0;
    rd_old = (c < NCH) ? m_cnt[c] : 0;
    for (int i = 0; i < NCH; i++) begin
      ce = (m_on && i == m_s) ? t1 : int'(tick);
      if (m_arm[i] && ce)
        m_cnt[i] = (m_mode[i] && tcv[i]) ? m_rld[i] : ((m_cnt[i] + 65535) % 65536);
      m_out[i] = m_mode[i] ? tcv[i] : (m_out[i] | tcv[i]);
    end
    m_stb = (m_on && tcv[m_s]) ? 1 : 0;
    m_ack = int'(gp_req);
    m_err = (gp_req && gbad) ? 1 : 0;
    if (gp_req && !gbad) begin
      if (gp_op == 0) m_rd = rd_old;
      else if (gp_op == 1) begin
        m_cnt[c] = int'(gp_wdata); m_rld[c] = int'(gp_wdata); m_arm[c] = 1; m_out[c] = 0;
      end else if (gp_op == 2) begin
        m_mode[c] = int'(gp_mode); m_arm[c] = 0; m_out[c] = 0;
      end
    end
    if (sok) begin
      m_on = 1; m_ldf = 1; m_f = a; m_s = b; m_fd = m_a1;
      m_mode[a] = 1; m_mode[b] = 1; m_out[a] = 0; m_out[b] = 0;
      m_arm[a] = 0; m_arm[b] = 1; m_cnt[b] = m_a2; m_rld[b] = m_a2;
    end else if (m_ldf) begin
      m_ldf = 0; m_arm[m_f] = 1; m_cnt[m_f] = m_fd; m_rld[m_f] = m_fd;
    end
    if (pok) begin
      m_on = 0; m_ldf = 0;
      m_mode[m_f] = 0; m_mode[m_s] = 0; m_arm[m_f] = 0; m_arm[m_s] = 0;
      m_out[m_f] = 0; m_out[m_s] = 0;
    end
    if (div_update) begin
      m_a1 = m_p1 % 65536; m_a2 = m_p2 % 65536;
      m_bad = (m_p1 < 2 || m_p2 < 2) ? 1 : 0;
    end
    if (nxt_wr) begin
      if (nxt_sel) m_p2 = int'(nxt_val); else m_p1 = int'(nxt_val);
    end
  endtask

  initial m_reset();
  always @(posedge clk) begin
    if (!rst_n) m_reset(); else m_step();
  end

  // compare against the model every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < NCH; i++) begin
        chk("R1", "ch_out vs model", int'(ch_out[i]), m_out[i]);
        chk("R6", "busy vs model", int'(busy[i]), (m_on && (i == m_f || i == m_s)) ? 1 : 0);
      end
      chk("R2", "pacer_strobe vs model", int'(pacer_strobe), m_stb);
      chk("R4", "pacer_on vs model", int'(pacer_on), m_on);
      chk("R5", "div_bad vs model", int'(div_bad), m_bad);
      chk("R7", "gp_ack vs model", int'(gp_ack), m_ack);
      chk("R7", "gp_err vs model", int'(gp_err), m_err);
      chk("R7", "gp_rdata vs model", int'(gp_rdata), m_rd);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask
  task automatic set_pend(bit sel, int val);
    nxt_wr = 1; nxt_sel = sel; nxt_val = 17'(val); cyc(); nxt_wr = 0;
  endtask
  task automatic do_update();
    div_update = 1; cyc(); div_update = 0;
  endtask
  task automatic do_start(int a, int b);
    start_req = 1; start_first = 2'(a); start_second = 2'(b); cyc(); start_req = 0;
  endtask
  task automatic do_stop();
    stop_req = 1; cyc(); stop_req = 0;
  endtask
  task automatic do_gp(int op, int ch, int data, bit md);
    gp_req = 1; gp_op = 2'(op); gp_chan = 2'(ch); gp_wdata = 16'(data); gp_mode = md;
    cyc(); gp_req = 0;
  endtask
  task automatic until_strobe(output int n);
    n = 0;
    do begin cyc(); n++; end while (!pacer_strobe);
  endtask

  initial begin
    int n;
    cyc(3);
    chk("R8", "reset outputs", int'({div_bad, gp_ack, gp_err, pacer_strobe, pacer_on, busy, ch_out}), 0);
    rst_n = 1;
    cyc(2);

    // R5/R3/R2: divisors 2 and 3
    set_pend(0, 2); set_pend(1, 3); do_update();
    chk("R5", "div_bad after valid update", int'(div_bad), 0);
    do_start(0, 1);
    chk("R4", "pacer_on after start", int'(pacer_on), 1);
    chk("R6", "busy pair 0,1", int'(busy), 3);
    until_strobe(n);
    chk("R3", "first strobe delay", n, 7);
    until_strobe(n);
    chk("R2", "strobe period 2x3", n, 6);
    set_pend(0, 4);
    until_strobe(n);
    until_strobe(n);
    chk("R5", "pending write not applied", n, 6);
    do_gp(0, 0, 0, 0);
    chk("R7", "busy channel refused", int'({gp_ack, gp_err}), 3);
    do_start(2, 0);
    chk("R4", "start while running ignored", int'(busy), 3);

    do_stop();
    chk("R4", "stopped", int'(pacer_on), 0);
    chk("R6", "busy cleared", int'(busy), 0);
    n = 0;
    repeat (20) begin cyc(); n += int'(pacer_strobe); end
    chk("R4", "no strobe after stop", n, 0);

    // R1/R7: general-purpose use
    do_gp(2, 0, 0, 1);
    chk("R7", "mode accepted", int'({gp_ack, gp_err}), 2);
    do_gp(1, 0, 4, 0);
    n = 0;
    do begin cyc(); n++; end while (!ch_out[0]);
    chk("R1", "rate mode first pulse", n, 4);
    n = 0;
    do begin cyc(); n++; end while (!ch_out[0]);
    chk("R1", "rate mode period", n, 4);
    do_gp(2, 1, 0, 0);
    do_gp(1, 1, 3, 0);
    cyc(2);
    chk("R1", "count mode not yet expired", int'(ch_out[1]), 0);
    cyc();
    chk("R1", "count mode expired", int'(ch_out[1]), 1);
    cyc(10);
    chk("R1", "count mode output holds", int'(ch_out[1]), 1);
    do_gp(2, 1, 0, 0);
    do_gp(0, 1, 0, 0);
    cyc(5);
    do_gp(0, 1, 0, 0);
    chk("R4", "unloaded counter does not move", int'(gp_rdata), int'(u_rd_prev()));
    do_gp(3, 2, 0, 0);
    chk("R7", "op 3 refused", int'(gp_err), 1);
    do_gp(0, 3, 0, 0);
    chk("R7", "channel 3 refused", int'(gp_err), 1);

    // R5: update applies the pending pair
    set_pend(1, 3); do_update();
    do_start(0, 1);
    until_strobe(n);
    until_strobe(n);
    chk("R2", "strobe period 4x3", n, 12);
    do_stop();
    set_pend(1, 1); do_update();
    chk("R5", "divisor 1 flagged", int'(div_bad), 1);
    set_pend(1, 0); do_update();
    chk("R5", "divisor 0 flagged", int'(div_bad), 1);

    // R4: ignored starts
    do_start(1, 1);
    chk("R4", "same channel ignored", int'(pacer_on), 0);
    do_start(3, 0);
    chk("R4", "channel 3 ignored", int'({pacer_on, busy}), 0);

    // R5: 65536 masked to full count
    set_pend(0, 65536); set_pend(1, 2); do_update();
    chk("R5", "65536 accepted", int'(div_bad), 0);
    do_start(2, 0);
    n = 0;
    do begin cyc(); n++; end while (!ch_out[2]);
    chk("R5", "full count first stage", n, 65537);
    do_stop();

    // random phase against the model
    for (int k = 0; k < 4000; k++) begin
      tick = ($urandom % 4) != 0;
      nxt_wr = ($urandom % 16) == 0; nxt_sel = $urandom % 2; nxt_val = 17'($urandom % 6);
      div_update = ($urandom % 20) == 0;
      start_req = ($urandom % 30) == 0; start_first = 2'($urandom % 4);
      start_second = 2'($urandom % 4);
      stop_req = ($urandom % 200) == 0;
      gp_req = ($urandom % 5) == 0; gp_op = 2'($urandom % 4); gp_chan = 2'($urandom % 4);
      gp_mode = $urandom % 2; gp_wdata = 16'($urandom % 8);
      cyc();
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  logic [15:0] rd_hold;
  always @(negedge clk) if (gp_ack && !gp_err && gp_op == 2'd0 && !gp_req) rd_hold <= gp_rdata;
  function automatic logic [15:0] u_rd_prev();
    return rd_hold;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog expired: got 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule